// File: doc/BRIEF.md
# Selectable Parity and Error-Correcting Code Checker

This block guards 16-bit words held in memory. It runs in one of three modes, held in a small control register: no checking, single-bit parity (even or odd), or a 6-bit Hamming code. The Hamming code has five position bits plus one overall bit. It corrects any single-bit error and detects any double-bit error. On a write the block computes, without a clock stage, the check bits that memory must store next to the word. On a read the memory returns the word and the stored bits. The block checks them and registers its verdict for exactly one cycle.

In parity mode a fault shows on an active-low error output. In code mode the block reports an active-high single-error handshake or a double-error flag, together with a syndrome that locates the bad bit. A downstream corrector can use that syndrome to flip the bit. The block resets to the no-checking mode, in which nothing it reports can go active.

Top module: `memCheckUnit`

## Requirements
- R1: After reset the mode is off, `parErrN` is 1, `sglErr` and `dblErr` are 0, and `syndrome` is 0.
- R2: When `cfgWe` is high at a rising edge, that edge loads `cfgMode` and `cfgOdd`. The codes are 0 = off, 1 = parity, 2 = code, and 3 = off. The new mode governs reads strobed from the following cycle on. A read strobed in the same cycle as the load is judged under the old mode.
- R3: In off mode `chkOut` is 0. A strobed read leaves `parErrN` at 1, `sglErr` and `dblErr` at 0, and `syndrome` at 0, whatever the data and check inputs are.
- R4: In parity mode `chkOut[0]` is the XOR of all data bits when `cfgOdd` was 0, and its inverse when `cfgOdd` was 1. `chkOut[5:1]` is 0.
- R5: In parity mode a strobed read drives `parErrN` low in the next cycle when the XOR of `dataIn` and `chkIn[0]` is 1 (even) or 0 (odd). Otherwise `parErrN` stays high. `chkIn[5:1]` has no effect.
- R6: In code mode each data bit j is given a codeword position. The data bits take, in ascending order, the positions from 1 upward that are not powers of two (3, 5, 6, 7, 9, ...). `chkOut[k]` (k = 0..4) is the XOR of the data bits whose position has bit k set. `chkOut[5]` is the XOR of all data bits and of `chkOut[4:0]`.
- R7: In code mode a strobed read registers `syndrome` for the next cycle. `syndrome[4:0]` is `chkIn[4:0]` XOR the bits recomputed from `dataIn`. `syndrome[5]` is the XOR of all bits of `dataIn` and `chkIn`. A word with its own check bits gives `syndrome` 0 and no flags.
- R8: In code mode, when `syndrome[5]` is 1, `sglErr` is 1 for that cycle. `syndrome[4:0]` then holds the position of the flipped bit, and 0 means the overall bit itself flipped. `parErrN` stays 1 in this mode.
- R9: In code mode, when `syndrome[5]` is 0 and `syndrome[4:0]` is not 0, `dblErr` is 1 for that cycle.
- R10: In a cycle after an edge without a strobed read (`accStb` low, or `accRead` low for a write), all flags are inactive and `syndrome` is 0. Each result therefore lasts one cycle.
- R11: At most one of `parErrN` low, `sglErr` and `dblErr` is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load strobe for the mode register |
| cfgMode | input | 2 | Mode code to load |
| cfgOdd | input | 1 | Parity sense to load, 1 = odd |
| accStb | input | 1 | Memory access strobe |
| accRead | input | 1 | 1 = read access, 0 = write access |
| dataIn | input | 16 | Data word written or read |
| chkIn | input | 6 | Check bits returned by memory on a read |
| chkOut | output | 6 | Check bits to store for `dataIn` |
| parErrN | output | 1 | Active-low parity error, one cycle |
| sglErr | output | 1 | Correctable single error, one cycle |
| dblErr | output | 1 | Uncorrectable double error, one cycle |
| syndrome | output | 6 | Error syndrome, overall bit on top |

## Verification
The assertions take for granted that `rstN` is held low through the first clock edge. They also take for granted that on a strobed read `dataIn` and `chkIn` are stable across the sampling edge, and that `cfgWe` is a single-cycle pulse whose mode code takes effect only at that edge. The bench drives every input on the falling edge, so each value is settled long before the edge that samples it. It changes the mode only through a task that raises `cfgWe` for one cycle. Corruption is always applied on top of check bits the bench computed itself, as zero, one or two flipped bits, so the assertions see every class of syndrome they reason about.

// File: rtl/memCheckPkg.sv
package memCheckPkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PAR  = 2'd1,
    MODE_EDAC = 2'd2,
    MODE_RSVD = 2'd3
  } modeE;

  // strobes the control half hands to the datapath
  typedef struct packed {
    logic genPar;
    logic genEdac;
    logic oddSel;
    logic evalPar;
    logic evalEdac;
    logic capture;
  } ctrlStrobeS;

  // number of position bits needed to cover dataW data bits
  function automatic int hamWidth(input int dataW);
    for (int r = 1; r < 31; r++) begin
      if ((1 << r) >= dataW + r + 1) return r;
    end
    return 31;
  endfunction

  // codeword position of data bit j: the j-th non power of two from 3 upward
  function automatic int dataPos(input int j);
    int cnt;
    cnt = 0;
    for (int p = 3; p < 65536; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/memCheckCtrl.sv
module memCheckCtrl
  import memCheckPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgMode,
  input  logic       cfgOdd,
  input  logic       accStb,
  input  logic       accRead,
  output ctrlStrobeS ctl
);

  modeE modeQ;
  logic oddQ;
  logic isPar;
  logic isEdac;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
      oddQ  <= 1'b0;
    end else if (cfgWe) begin
      modeQ <= modeE'(cfgMode);
      oddQ  <= cfgOdd;
    end
  end

  // reserved code behaves as off
  always_comb begin
    isPar  = 1'b0;
    isEdac = 1'b0;
    unique case (modeQ)
      MODE_PAR:  isPar  = 1'b1;
      MODE_EDAC: isEdac = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    ctl.genPar   = isPar;
    ctl.genEdac  = isEdac;
    ctl.oddSel   = oddQ;
    ctl.evalPar  = isPar;
    ctl.evalEdac = isEdac;
    ctl.capture  = accStb & accRead;
  end

endmodule

// File: rtl/memCheckPath.sv
module memCheckPath
  import memCheckPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5,
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeS        ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CHK_W-1:0]  chkIn,
  output logic [CHK_W-1:0]  chkOut,
  output logic              parErrN,
  output logic              sglErr,
  output logic              dblErr,
  output logic [CHK_W-1:0]  syndrome
);

  logic [DATA_W-1:0] selBits [HAM_W];
  logic [HAM_W-1:0]  hamGen;
  logic              dataPar;
  logic              overallGen;
  logic [HAM_W-1:0]  synHam;
  logic              synAll;
  logic              parBad;

  // each position bit covers the data bits whose position has that bit set
  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    for (genvar j = 0; j < DATA_W; j++) begin : g_sel
      if (((dataPos(j) >> k) & 1) == 1) begin : g_on
        assign selBits[k][j] = dataIn[j];
      end else begin : g_off
        assign selBits[k][j] = 1'b0;
      end
    end
    assign hamGen[k] = ^selBits[k];
  end

  assign dataPar    = ^dataIn;
  assign overallGen = dataPar ^ (^hamGen);

  always_comb begin
    chkOut = '0;
    if (ctl.genEdac) begin
      chkOut = {overallGen, hamGen};
    end else if (ctl.genPar) begin
      chkOut[0] = dataPar ^ ctl.oddSel;
    end
  end

  // read-side evaluation
  assign synHam = hamGen ^ chkIn[HAM_W-1:0];
  assign synAll = dataPar ^ (^chkIn);
  assign parBad = dataPar ^ chkIn[0] ^ ctl.oddSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parErrN  <= 1'b1;
      sglErr   <= 1'b0;
      dblErr   <= 1'b0;
      syndrome <= '0;
    end else if (ctl.capture) begin
      parErrN  <= ~(ctl.evalPar & parBad);
      sglErr   <= ctl.evalEdac & synAll;
      dblErr   <= ctl.evalEdac & ~synAll & (|synHam);
      syndrome <= ctl.evalEdac ? {synAll, synHam} : '0;
    end else begin
      parErrN  <= 1'b1;
      sglErr   <= 1'b0;
      dblErr   <= 1'b0;
      syndrome <= '0;
    end
  end

endmodule

// File: rtl/memCheckUnit.sv
module memCheckUnit
  import memCheckPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HAM_W = hamWidth(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgOdd,
  input  logic              accStb,
  input  logic              accRead,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CHK_W-1:0]  chkIn,
  output logic [CHK_W-1:0]  chkOut,
  output logic              parErrN,
  output logic              sglErr,
  output logic              dblErr,
  output logic [CHK_W-1:0]  syndrome
);

  ctrlStrobeS ctl;

  memCheckCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgMode (cfgMode),
    .cfgOdd  (cfgOdd),
    .accStb  (accStb),
    .accRead (accRead),
    .ctl     (ctl)
  );

  memCheckPath #(
    .DATA_W (DATA_W),
    .HAM_W  (HAM_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dataIn   (dataIn),
    .chkIn    (chkIn),
    .chkOut   (chkOut),
    .parErrN  (parErrN),
    .sglErr   (sglErr),
    .dblErr   (dblErr),
    .syndrome (syndrome)
  );

endmodule

// File: rtl/memCheckSva.sv
module memCheckSva #(
  parameter int CHK_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [1:0]       cfgMode,
  input logic             accStb,
  input logic             accRead,
  input logic [CHK_W-1:0] chkIn,
  input logic [CHK_W-1:0] chkOut,
  input logic             parErrN,
  input logic             sglErr,
  input logic             dblErr,
  input logic [CHK_W-1:0] syndrome
);

  // shadow of the programmed mode, built from the configuration port
  logic [1:0] modeSh;
  always_ff @(posedge clk) begin
    if (!rstN) modeSh <= 2'd0;
    else if (cfgWe) modeSh <= cfgMode;
  end

  logic rdStb;
  assign rdStb = accStb & accRead;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (parErrN && !sglErr && !dblErr && syndrome == '0));

  // R3: off and reserved codes never raise anything
  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && (modeSh == 2'd0 || modeSh == 2'd3))
      |=> (parErrN && !sglErr && !dblErr && syndrome == '0));

  assert_par_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && modeSh == 2'd1 && chkIn[0] == chkOut[0]) |=> parErrN);

  // R6/R7: a word read back with its own generated bits is clean
  assert_edac_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && modeSh == 2'd2 && chkIn == chkOut)
      |=> (!sglErr && !dblErr && syndrome == '0));

  assert_sgl_overall_R8: assert property (@(posedge clk) disable iff (!rstN)
    sglErr |-> syndrome[CHK_W-1]);

  assert_dbl_syndrome_R9: assert property (@(posedge clk) disable iff (!rstN)
    dblErr |-> (!syndrome[CHK_W-1] && syndrome[CHK_W-2:0] != '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> (parErrN && !sglErr && !dblErr && syndrome == '0));

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~parErrN, sglErr, dblErr}) <= 1);

endmodule

bind memCheckUnit memCheckSva #(.CHK_W(CHK_W)) uSva (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .cfgMode  (cfgMode),
  .accStb   (accStb),
  .accRead  (accRead),
  .chkIn    (chkIn),
  .chkOut   (chkOut),
  .parErrN  (parErrN),
  .sglErr   (sglErr),
  .dblErr   (dblErr),
  .syndrome (syndrome)
);

// File: tb/tb_memCheckUnit.sv
`timescale 1ns/1ps
module tb_memCheckUnit;

  localparam int DW = 16;
  localparam int HW = 5;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgMode = 2'd0;
  logic          cfgOdd = 1'b0;
  logic          accStb = 1'b0;
  logic          accRead = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [CW-1:0] chkIn = '0;
  logic [CW-1:0] chkOut;
  logic          parErrN;
  logic          sglErr;
  logic          dblErr;
  logic [CW-1:0] syndrome;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench view of the programmed mode
  int  curMode = 0;
  bit  curOdd = 0;

  always #4 clk = ~clk;

  memCheckUnit dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgOdd(cfgOdd),
    .accStb(accStb), .accRead(accRead), .dataIn(dataIn), .chkIn(chkIn),
    .chkOut(chkOut), .parErrN(parErrN), .sglErr(sglErr), .dblErr(dblErr),
    .syndrome(syndrome)
  );

  function automatic int posOf(input int j);
    int n;
    n = -1;
    for (int p = 1; p < 64; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        n++;
        if (n == j) return p;
      end
    end
    return 0;
  endfunction

  function automatic logic [CW-1:0] codeRef(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    logic ov;
    h = '0;
    ov = 1'b0;
    for (int j = 0; j < DW; j++) begin
      for (int k = 0; k < HW; k++)
        if (((posOf(j) >> k) & 1) == 1) h[k] = h[k] ^ d[j];
      ov = ov ^ d[j];
    end
    for (int k = 0; k < HW; k++) ov = ov ^ h[k];
    return {ov, h};
  endfunction

  function automatic logic [CW-1:0] genRef(input int m, input bit odd, input logic [DW-1:0] d);
    logic p;
    p = 1'b0;
    for (int j = 0; j < DW; j++) p = p ^ d[j];
    if (m == 1) return {5'b0, p ^ odd};
    if (m == 2) return codeRef(d);
    return '0;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic setMode(input int m, input bit odd);
    cfgWe = 1'b1;
    cfgMode = m[1:0];
    cfgOdd = odd;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
    curMode = (m == 3) ? 0 : m;
    curOdd = odd;
  endtask

  // strobed read; checks the registered result one cycle later
  task automatic doRead(input logic [DW-1:0] d, input logic [CW-1:0] c);
    logic p, expPar, expSgl, expDbl;
    logic [CW-1:0] expSyn;
    string tag;
    dataIn = d;
    chkIn = c;
    accStb = 1'b1;
    accRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    accStb = 1'b0;
    p = 1'b0;
    for (int j = 0; j < DW; j++) p = p ^ d[j];
    expPar = 1'b1;
    expSgl = 1'b0;
    expDbl = 1'b0;
    expSyn = '0;
    tag = "R3";
    if (curMode == 1) begin
      tag = "R5";
      expPar = ~((p ^ c[0]) ^ curOdd);
    end else if (curMode == 2) begin
      expSyn = codeRef(d) ^ c;
      expSyn[CW-1] = p ^ (^c);
      expSgl = expSyn[CW-1];
      expDbl = !expSyn[CW-1] && (expSyn[CW-2:0] != '0);
      tag = expSgl ? "R8" : (expDbl ? "R9" : "R7");
    end
    check(tag, {1'b0, parErrN, sglErr, dblErr, syndrome},
               {1'b0, expPar, expSgl, expDbl, expSyn});
  endtask

  task automatic doWrite(input logic [DW-1:0] d);
    dataIn = d;
    chkIn = '1;
    accStb = 1'b1;
    accRead = 1'b0;
    #1;
    check(curMode == 2 ? "R6" : (curMode == 1 ? "R4" : "R3"),
          {4'b0, chkOut}, {4'b0, genRef(curMode, curOdd, d)});
    @(posedge clk);
    @(negedge clk);
    accStb = 1'b0;
    check("R10", {1'b0, parErrN, sglErr, dblErr, syndrome}, {1'b0, 1'b1, 1'b0, 1'b0, 6'b0});
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [DW-1:0] d;
    logic [CW-1:0] c;
    int b1, b2;
    void'($urandom(32'd1757));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {1'b0, parErrN, sglErr, dblErr, syndrome}, {1'b0, 1'b1, 1'b0, 1'b0, 6'b0});
    dataIn = 16'hBEEF;
    #1;
    check("R1", {4'b0, chkOut}, 10'b0);

    // R3 off mode ignores garbage
    doRead(16'h1234, 6'h3F);
    doRead(16'hFFFF, 6'h15);

    // R2 load in same cycle as read is judged under old mode
    cfgWe = 1'b1; cfgMode = 2'd1; cfgOdd = 1'b0;
    dataIn = 16'h0001; chkIn = 6'h00; accStb = 1'b1; accRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0; accStb = 1'b0;
    check("R2", {9'b0, parErrN}, 10'b1);
    curMode = 1; curOdd = 0;
    doRead(16'h0001, 6'h00);          // even parity error now reported
    check("R2", {9'b0, parErrN}, 10'b0);

    // parity, even and odd, upper check bits ignored
    for (int i = 0; i < 40; i++) begin
      d = 16'($urandom);
      c = 6'($urandom);
      doRead(d, c);
    end
    doWrite(16'h00FF);
    setMode(1, 1);
    doWrite(16'h0007);
    doRead(16'h0007, 6'h3E);          // odd: 3 ones + 0 -> good, upper ignored
    doRead(16'h0007, 6'h01);          // odd: 4 ones -> error
    for (int i = 0; i < 40; i++) begin
      d = 16'($urandom);
      doRead(d, {5'($urandom), 1'($urandom)});
    end

    // code mode
    setMode(2, 0);
    doWrite(16'h0000);
    doWrite(16'hFFFF);
    doRead(16'hA5A5, codeRef(16'hA5A5));               // clean
    doRead(16'hA5A5 ^ 16'h0001, codeRef(16'hA5A5));    // data bit 0 -> pos 3
    check("R8", {4'b0, syndrome}, {4'b0, 6'b100011});
    doRead(16'hA5A5, codeRef(16'hA5A5) ^ 6'b100000);   // overall bit only
    check("R8", {4'b0, syndrome}, {4'b0, 6'b100000});
    doRead(16'h8000, codeRef(16'h0000));               // bit 15 -> pos 21
    check("R8", {4'b0, syndrome}, {4'b0, 6'b110101});
    doRead(16'h0003, codeRef(16'h0000));               // two data bits
    for (int i = 0; i < 120; i++) begin
      d = 16'($urandom);
      c = codeRef(d);
      b1 = $urandom_range(0, 21);
      b2 = $urandom_range(0, 21);
      case ($urandom_range(0, 2))
        0: ;
        1: if (b1 < DW) d[b1] = ~d[b1]; else c[b1-DW] = ~c[b1-DW];
        default: begin
          if (b2 == b1) b2 = (b1 + 1) % 22;
          if (b1 < DW) d[b1] = ~d[b1]; else c[b1-DW] = ~c[b1-DW];
          if (b2 < DW) d[b2] = ~d[b2]; else c[b2-DW] = ~c[b2-DW];
        end
      endcase
      doRead(d, c);
      if ((i % 10) == 0) doWrite(16'($urandom));
    end

    // reserved code acts as off
    setMode(3, 0);
    doWrite(16'h5A5A);
    doRead(16'h5A5A, 6'h2B);
    finishRun();
  end

endmodule